// File: doc/BRIEF.md
# Real-Time Clock Timebase and Update Sequencer

This block is the front end of a real-time clock. It counts a 32.768 kHz clock-enable tick through a 15-stage binary chain. Once per second it issues a one-cycle update strobe to a separate calendar counter. From the same chain it derives a rate-selectable square wave and a periodic-interrupt flag. A single control byte can be written and read. It holds a three-bit divider-control field and a four-bit rate code. Bit 7 of the byte is a read-only update-warning flag.

The divider runs only for one control pattern. Entering that pattern from any other value loads the chain at its midpoint, so the first strobe arrives half a second later. The warning flag rises a fixed number of ticks before every strobe, so software can tell when the calendar is safe to read. An external inhibit input blocks strobes and silences the warning. A power-on reset clears everything. A separate system reset clears only the interrupt flag.

Top module: `rtc_timebase`

## Requirements
- R1: The control byte reads as {warning flag at bit 7, divider-control at bits 6:4, rate code at bits 3:0}. A write loads bits 6:0 and ignores bit 7.
- R2: The chain advances by one on each clock where `tick_i` is 1 and divider-control is 3'b010. For the values 000, 001, 011, 100 and 101 the chain is frozen at its current count.
- R3: Divider-control 3'b110 or 3'b111 clears the chain and holds it at zero, so no strobe is issued and no tap toggles.
- R4: Writing 3'b010 when the field held another value causes a strobe 16384 ticks later, then one every 32768 ticks. Rewriting 3'b010 while running does not restart the chain. Each strobe lasts one clock.
- R5: The warning flag rises 8 ticks before each strobe, stays high for 8 ticks after it, then clears.
- R6: While `set_i` is 1, no strobe is issued and the warning flag reads 0 from the next clock. After release, a strobe is issued only after a full 8-tick warning.
- R7: Square-wave period in ticks: code 1 gives 128, code 2 gives 256, and codes 3 to 15 give 2^(code-1) (8192 Hz down to 2 Hz).
- R8: `sqw_o` is the selected tap with equal high and low tick counts. It is held at 0 when `sqwe_i` is 0 or the rate code is 0.
- R9: `pi_flag_o` is set in the same clock that the selected tap rises, when `pie_i` is 1 and the code is nonzero. A pulse on `pi_clr_i` clears it, and a new rise wins over a clear.
- R10: `rst_n` low clears `pi_flag_o` only. The control byte, the chain and the square wave are unchanged.
- R11: `por_n` low clears the control byte, the chain and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on clear, active low |
| rst_n | input | 1 | Synchronous system reset, active low, clears the interrupt flag |
| tick_i | input | 1 | 32.768 kHz clock enable |
| wr_en_i | input | 1 | Control byte write strobe |
| wr_data_i | input | 8 | Control byte write data |
| rd_data_o | output | 8 | Control byte read data |
| set_i | input | 1 | Update inhibit |
| pie_i | input | 1 | Periodic-interrupt enable |
| sqwe_i | input | 1 | Square-wave output enable |
| pi_clr_i | input | 1 | Host read of the interrupt flag, clears it |
| upd_o | output | 1 | One-cycle update strobe to the calendar |
| uip_o | output | 1 | Update warning flag |
| sqw_o | output | 1 | Square-wave output |
| pi_flag_o | output | 1 | Periodic-interrupt flag |

## Verification
The bench builds the block with its defaults: a 15-stage chain and warning windows of 8 ticks on each side of the strobe. The tick is held high during the update phase, so the half-second first strobe and the next full second fall within about 82,000 clocks. This lets the bench pin down exact cycle positions for the warning edges, the inhibit window and a mid-run rewrite. For the rate taps the tick is gapped at random. Periods and duty are measured in ticks for codes up to 11, together with the special codes 1 and 2.

// File: rtl/rtcpre_pkg.sv
package rtcpre_pkg;

    localparam logic [2:0] DIV_RUN = 3'b010;
    localparam int         TAP_TOP = 13;

    typedef struct packed {
        logic [2:0] div;
        logic [3:0] rs;
    } ctrl_t;

    function automatic int tap_index(input int code);
        if (code == 1)      return 6;
        else if (code == 2) return 7;
        else if (code >= 3) return code - 2;
        else                return 0;
    endfunction

    function automatic logic is_hold(input logic [2:0] div);
        return div[2:1] == 2'b11;
    endfunction

endpackage

// File: rtl/rtcpre_ctrl.sv
module rtcpre_ctrl
    import rtcpre_pkg::*;
(
    input  logic        clk,
    input  logic        por_n,
    input  logic        wr_en_i,
    input  logic [7:0]  wr_data_i,
    input  logic        uip_i,
    output ctrl_t       ctrl_o,
    output logic        start_o,
    output logic [7:0]  rd_data_o
);

    ctrl_t ctrl_d, ctrl_q;
    logic  start_d;

    always_comb begin
        ctrl_d  = ctrl_q;
        start_d = 1'b0;
        if (wr_en_i) begin
            ctrl_d.div = wr_data_i[6:4];
            ctrl_d.rs  = wr_data_i[3:0];
            start_d    = (wr_data_i[6:4] == DIV_RUN) && (ctrl_q.div != DIV_RUN);
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl_o    = ctrl_q;
    assign start_o   = start_d;
    assign rd_data_o = {uip_i, ctrl_q.div, ctrl_q.rs};

    // R1
    wr_load_chk: assert property (@(posedge clk) disable iff (!por_n)
        wr_en_i |=> (rd_data_o[6:0] == $past(wr_data_i[6:0])));

endmodule

// File: rtl/rtcpre_chain.sv
module rtcpre_chain
    import rtcpre_pkg::*;
#(
    parameter int DIV_W = 15,
    parameter int LEAD  = 8,
    parameter int TAIL  = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             tick_i,
    input  logic [2:0]       div_i,
    input  logic             start_i,
    input  logic             set_i,
    output logic [DIV_W-1:0] cnt_o,
    output logic [DIV_W-1:0] cnt_nxt_o,
    output logic             upd_o,
    output logic             uip_o
);

    localparam logic [DIV_W-1:0] CNT_MAX  = '1;
    localparam logic [DIV_W-1:0] CNT_HALF = DIV_W'(1) << (DIV_W - 1);
    localparam logic [DIV_W-1:0] ARM_AT   = CNT_MAX - DIV_W'(LEAD);
    localparam logic [DIV_W-1:0] TAIL_END = DIV_W'(TAIL - 1);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             arm;
        logic             tail;
        logic             upd;
    } chain_t;

    chain_t st_d, st_q;
    logic   running, hold;

    assign running = (div_i == DIV_RUN);
    assign hold    = is_hold(div_i);

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        if (start_i) begin
            st_d.cnt  = CNT_HALF;
            st_d.arm  = 1'b0;
            st_d.tail = 1'b0;
        end else if (hold) begin
            st_d.cnt  = '0;
            st_d.arm  = 1'b0;
            st_d.tail = 1'b0;
        end else if (running && tick_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == ARM_AT) st_d.arm = 1'b1;
            if (st_q.cnt == CNT_MAX && st_q.arm) begin
                st_d.upd  = 1'b1;
                st_d.tail = 1'b1;
                st_d.arm  = 1'b0;
            end
            if (st_q.tail && st_q.cnt == TAIL_END) st_d.tail = 1'b0;
        end
        if (set_i) begin
            st_d.arm  = 1'b0;
            st_d.tail = 1'b0;
            st_d.upd  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o     = st_q.cnt;
    assign cnt_nxt_o = st_d.cnt;
    assign upd_o     = st_q.upd;
    assign uip_o     = st_q.arm | st_q.tail;

    // R5
    warn_first_chk: assert property (@(posedge clk) disable iff (!por_n)
        st_q.upd |-> $past(st_q.arm));

    // R6
    set_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
        set_i |=> (!uip_o && !upd_o));

    // R3
    hold_clr_chk: assert property (@(posedge clk) disable iff (!por_n)
        (hold && !start_i) |=> (cnt_o == '0 && !upd_o));

    // R4
    upd_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
        upd_o |=> !upd_o);

endmodule

// File: rtl/rtcpre_tap.sv
module rtcpre_tap
    import rtcpre_pkg::*;
#(
    parameter int DIV_W = 15
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cnt_i,
    input  logic [DIV_W-1:0] cnt_nxt_i,
    input  logic [3:0]       rs_i,
    input  logic             pie_i,
    input  logic             sqwe_i,
    input  logic             clr_i,
    output logic             sqw_o,
    output logic             pi_o
);

    localparam int CODES = 16;

    logic [CODES-1:0] tap_now, tap_nxt;
    logic             rise, pi_d, pi_q;

    assign tap_now[0] = 1'b0;
    assign tap_nxt[0] = 1'b0;

    for (genvar g = 1; g < CODES; g++) begin : g_tap
        localparam int IDX = tap_index(g);
        assign tap_now[g] = cnt_i[IDX];
        assign tap_nxt[g] = cnt_nxt_i[IDX];
    end

    assign rise = !tap_now[rs_i] && tap_nxt[rs_i];

    always_comb begin
        pi_d = pi_q;
        if (clr_i)        pi_d = 1'b0;
        if (rise && pie_i) pi_d = 1'b1;
        if (!rst_n)       pi_d = 1'b0;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) pi_q <= 1'b0;
        else        pi_q <= pi_d;
    end

    assign sqw_o = sqwe_i && tap_now[rs_i];
    assign pi_o  = pi_q;

    // R9
    pie_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(pi_q) |-> ($past(pie_i) && $past(rs_i) != 4'd0));

    // R10
    rst_flag_chk: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> !pi_q);

endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase
    import rtcpre_pkg::*;
#(
    parameter int DIV_W = 15,
    parameter int LEAD  = 8,
    parameter int TAIL  = 8
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] rd_data_o,
    input  logic       set_i,
    input  logic       pie_i,
    input  logic       sqwe_i,
    input  logic       pi_clr_i,
    output logic       upd_o,
    output logic       uip_o,
    output logic       sqw_o,
    output logic       pi_flag_o
);

    ctrl_t            ctrl;
    logic             start;
    logic [DIV_W-1:0] cnt, cnt_nxt;

    rtcpre_ctrl u_ctrl (
        .clk       (clk),
        .por_n     (por_n),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .uip_i     (uip_o),
        .ctrl_o    (ctrl),
        .start_o   (start),
        .rd_data_o (rd_data_o)
    );

    rtcpre_chain #(.DIV_W(DIV_W), .LEAD(LEAD), .TAIL(TAIL)) u_chain (
        .clk       (clk),
        .por_n     (por_n),
        .tick_i    (tick_i),
        .div_i     (ctrl.div),
        .start_i   (start),
        .set_i     (set_i),
        .cnt_o     (cnt),
        .cnt_nxt_o (cnt_nxt),
        .upd_o     (upd_o),
        .uip_o     (uip_o)
    );

    rtcpre_tap #(.DIV_W(DIV_W)) u_tap (
        .clk       (clk),
        .por_n     (por_n),
        .rst_n     (rst_n),
        .cnt_i     (cnt),
        .cnt_nxt_i (cnt_nxt),
        .rs_i      (ctrl.rs),
        .pie_i     (pie_i),
        .sqwe_i    (sqwe_i),
        .clr_i     (pi_clr_i),
        .sqw_o     (sqw_o),
        .pi_o      (pi_flag_o)
    );

    // R8
    sqw_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!sqwe_i || rd_data_o[3:0] == 4'd0) |-> !sqw_o);

    // R10
    rst_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_n && !wr_en_i) |=> $stable(rd_data_o[6:0]));

endmodule

// File: tb/rtc_timebase_test.sv
module rtc_timebase_test;

    logic       clk = 1'b0;
    logic       por_n, rst_n, tick_i, wr_en_i, set_i, pie_i, sqwe_i, pi_clr_i;
    logic [7:0] wr_data_i, rd_data_o;
    logic       upd_o, uip_o, sqw_o, pi_flag_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    rtc_timebase #(.DIV_W(15), .LEAD(8), .TAIL(8)) uut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick_i(tick_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
        .set_i(set_i), .pie_i(pie_i), .sqwe_i(sqwe_i), .pi_clr_i(pi_clr_i),
        .upd_o(upd_o), .uip_o(uip_o), .sqw_o(sqw_o), .pi_flag_o(pi_flag_o)
    );

    function automatic int exp_period(input int code);
        if (code == 1) return 128;
        if (code == 2) return 256;
        return 1 << (code - 1);
    endfunction

    function automatic logic [7:0] exp_byte(input logic [2:0] div, input logic [3:0] rs);
        return {1'b0, div, rs};
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        wr_en_i   = 1'b1;
        wr_data_i = v;
        @(negedge clk);
        wr_en_i   = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            fails++;
            $display("FAIL watchdog R4 actual=%0d expected=%0d", cyc, 190000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic measure(input int code);
        int  acc = 0, mark = 0, hi = 0, rises = 0, guard = 0;
        bit  prev, s, clr_pend = 0;
        prev = sqw_o;
        while (rises < 3 && guard < 20000) begin
            @(negedge clk);
            guard++;
            s = sqw_o;
            if (s && !prev) begin
                rises++;
                // R9: flag rises with the tap
                if (rises >= 2) chk(pi_flag_o == 1'b1, "R9 flag on rise", pi_flag_o, 1);
                if (rises == 2) begin mark = acc; hi = 0; end
                if (rises == 3) begin
                    chk(acc - mark == exp_period(code), "R7 period", acc - mark, exp_period(code));
                    chk(hi * 2 == acc - mark, "R8 duty", hi * 2, acc - mark);
                end
            end else if (clr_pend && rises >= 2) begin
                chk(pi_flag_o == 1'b0, "R9 flag cleared", pi_flag_o, 0);
            end
            clr_pend = s && !prev;
            pi_clr_i = clr_pend;
            tick_i   = (($urandom % 4) != 0);
            acc += int'(tick_i);
            if (s && rises >= 2) hi += int'(tick_i);
            prev = s;
        end
        pi_clr_i = 1'b0;
        chk(rises == 3, "R7 tap running", rises, 3);
    endtask

    initial begin
        int n, urise, ufall, u1, u2, u3, bad;
        bit pu;
        logic [7:0] saved;
        logic       sq;
        void'($urandom(32'd12345));
        por_n = 1'b0; rst_n = 1'b1; tick_i = 1'b0; wr_en_i = 1'b0; wr_data_i = '0;
        set_i = 1'b0; pie_i = 1'b0; sqwe_i = 1'b0; pi_clr_i = 1'b0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        // R11
        chk(rd_data_o == 8'h00, "R11 byte", rd_data_o, 0);
        chk({upd_o, uip_o, sqw_o, pi_flag_o} == 4'b0, "R11 outputs", {upd_o, uip_o, sqw_o, pi_flag_o}, 0);

        // R1: bit 7 ignored on write
        tick_i = 1'b1;
        wr(8'hA5);
        chk(rd_data_o == exp_byte(3'b010, 4'd5), "R1 readback", rd_data_o, exp_byte(3'b010, 4'd5));

        n = 0; urise = -1; ufall = -1; u1 = -1; u2 = -1; u3 = -1; pu = 1'b0;
        while (n < 81913) begin
            @(negedge clk);
            n++;
            if (upd_o) begin
                if (u1 < 0) u1 = n; else if (u2 < 0) u2 = n; else u3 = n;
            end
            if (uip_o && !pu && urise < 0) urise = n;
            if (!uip_o && pu && ufall < 0) ufall = n;
            pu = uip_o;
            if (n == 16380) chk(rd_data_o[7] == 1'b1, "R1 warning bit", rd_data_o[7], 1);
            // R4: rewrite mid-run, must not restart
            if (n == 20000) begin wr_en_i = 1'b1; wr_data_i = 8'h25; end
            if (n == 20001) wr_en_i = 1'b0;
        end
        chk(u1 == 16384, "R4 first update", u1, 16384);
        chk(u2 == 49152, "R4 second update", u2, 49152);
        chk(u3 == -1, "R4 no extra update", u3, -1);
        chk(urise == 16376, "R5 warning rise", urise, 16376);
        chk(ufall == 16392, "R5 warning fall", ufall, 16392);
        chk(uip_o == 1'b1, "R5 warning before second wrap", uip_o, 1);

        // R6: inhibit during warning window
        @(negedge clk); n++;
        set_i = 1'b1;
        bad = 0;
        while (n < 81940) begin
            @(negedge clk);
            n++;
            if (uip_o || upd_o) bad++;
            if (n == 81918) set_i = 1'b0;
        end
        chk(bad == 0, "R6 inhibit", bad, 0);

        // R3: hold pattern clears chain
        sqwe_i = 1'b1;
        wr(8'h65);
        chk(rd_data_o == exp_byte(3'b110, 4'd5), "R3 readback", rd_data_o, exp_byte(3'b110, 4'd5));
        @(negedge clk);
        bad = 0;
        repeat (100) begin
            @(negedge clk);
            if (sqw_o || upd_o || uip_o) bad++;
        end
        chk(bad == 0, "R3 hold quiet", bad, 0);

        // R2: freeze with tap at 1
        wr(8'h23);
        @(negedge clk);
        wr(8'h03);
        bad = 0;
        repeat (50) begin
            @(negedge clk);
            if (!sqw_o) bad++;
        end
        chk(bad == 0, "R2 frozen tap", bad, 0);
        chk(rd_data_o == 8'h03, "R2 readback", rd_data_o, 8'h03);

        // R7/R8/R9 directed special codes then random codes
        pie_i = 1'b1;
        for (int c = 1; c <= 3; c++) begin
            wr(exp_byte(3'b010, 4'(c)));
            measure(c);
        end
        for (int k = 0; k < 6; k++) begin
            int c = 1 + int'($urandom % 11);
            wr(exp_byte(3'b010, 4'(c)));
            measure(c);
        end

        // R8/R9: enables off
        tick_i = 1'b1; pie_i = 1'b0; sqwe_i = 1'b0;
        wr(8'h23);
        pi_clr_i = 1'b1; @(negedge clk); pi_clr_i = 1'b0;
        bad = 0;
        repeat (200) begin
            @(negedge clk);
            if (sqw_o || pi_flag_o) bad++;
        end
        chk(bad == 0, "R8 R9 disabled", bad, 0);
        // R8: code zero
        pie_i = 1'b1; sqwe_i = 1'b1;
        wr(8'h20);
        bad = 0;
        repeat (300) begin
            @(negedge clk);
            if (sqw_o || pi_flag_o) bad++;
        end
        chk(bad == 0, "R8 code zero", bad, 0);

        // R10: system reset clears only the flag
        wr(8'h27);
        bad = 0;
        while (!pi_flag_o && bad < 300) begin @(negedge clk); bad++; end
        chk(pi_flag_o == 1'b1, "R10 flag set", pi_flag_o, 1);
        tick_i = 1'b0;
        @(negedge clk);
        saved = rd_data_o; sq = sqw_o;
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
        chk(pi_flag_o == 1'b0, "R10 flag cleared", pi_flag_o, 0);
        chk(rd_data_o == saved, "R10 byte kept", rd_data_o, saved);
        chk(sqw_o == sq, "R10 tap kept", sqw_o, sq);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule